// File: doc/BRIEF.md
# Binary64 to Integer Converter with Selectable Out-of-Range Policy

This unit takes a double-precision floating-point operand and produces a signed or unsigned integer of 32 or 64 bits, always delivered on a 64-bit result bus. The caller picks the integer type, a conversion-mode code and a rounding direction on every cycle. The result and all status flags appear one clock later. The block is a single registered stage with no handshake: whatever is presented at a rising edge is converted and shown until the next edge.

The conversion-mode code chooses how NaN and values that do not fit are handled. There are three policies. The first clamps to the type bounds and sends NaN to the type minimum. The second clamps in the same way but sends NaN to zero. The third wraps the rounded value modulo 2^N, and sends NaN and infinity to zero. The lowest mode bit can force rounding toward zero regardless of the rounding field.

Beside the integer, the unit reports four flags: invalid-convert, signalling-NaN, inexact, and whether rounding grew the magnitude. It also reports a sticky-style fraction-inexact copy, an integer-overflow indication gated by an enable, and a flag for an unusable mode code. When invalid trapping is enabled and an invalid condition occurs, the write-enable drops so the caller leaves its destination untouched.

Top module: `fp64_to_int_cvt`

## Requirements
- R1: Mode codes 6 and 7 (mode bits [2:1] = 11) are unusable: the bad-mode flag is 1, write-enable is 0, the result is 0 and every other flag is 0.
- R2: When mode bit 0 is 1, rounding is toward zero. Otherwise the rounding field selects the direction: 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R3: Mode codes 0 and 1 clamp. A NaN gives the type minimum, a rounded value above the type maximum gives the maximum, and a rounded value below the type minimum gives the minimum. Type code 0 is signed 32-bit, 1 is unsigned 32-bit, 2 is signed 64-bit and 3 is unsigned 64-bit.
- R4: Mode codes 2 and 3 clamp exactly as in R3, except that a NaN gives 0.
- R5: Mode codes 4 and 5 give 0 for NaN or infinity. Otherwise they give the rounded value reduced modulo 2^32 or 2^64, read as the target type.
- R6: A signed 32-bit result has bit 31 copied into bits 63:32. An unsigned 32-bit result has bits 63:32 cleared.
- R7: Invalid-convert is 1 exactly when the operand is NaN, infinite, or rounds to a value outside the type range. When it is 1, inexact and fraction-rounded are 0.
- R8: When invalid-convert is 0, inexact is 1 exactly when the rounded value differs from the operand. Fraction-rounded is 1 exactly when the rounded magnitude exceeds the operand magnitude. Fraction-inexact equals inexact.
- R9: The signalling-NaN flag is 1 for an operand with all-ones exponent (bits 62:52), a non-zero fraction and fraction bit 51 clear. Such an operand also raises invalid-convert. A quiet NaN leaves the signalling-NaN flag at 0.
- R10: When invalid-enable is 1 and either signalling-NaN or invalid-convert is raised, write-enable is 0, the result is 0, and fraction-rounded and fraction-inexact are 0.
- R11: The integer-overflow output equals overflow-enable AND invalid-convert.
- R12: Reset clears all outputs. After reset, outputs reflect the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 64 | Binary64 operand |
| int_type_i | input | 2 | Target integer type code |
| conv_mode_i | input | 3 | Conversion-mode code |
| rnd_mode_i | input | 2 | Rounding direction field |
| inv_en_i | input | 1 | Invalid-operation trap enable |
| ovf_en_i | input | 1 | Integer-overflow report enable |
| result_o | output | 64 | Converted integer |
| wr_en_o | output | 1 | Destination write permitted |
| inv_cvt_o | output | 1 | Invalid conversion |
| snan_o | output | 1 | Signalling-NaN operand |
| inexact_o | output | 1 | Result differs from operand |
| frac_rnd_o | output | 1 | Rounding increased the magnitude |
| frac_inx_o | output | 1 | Fraction-inexact status |
| int_ovf_o | output | 1 | Integer overflow, gated by enable |
| bad_mode_o | output | 1 | Unusable mode code |

## Verification
Rounding and range clamping can act on the same operand in one cycle. For example, 2147483647.5 rounded up becomes 2^31, which then overflows a signed 32-bit type. Likewise, -0.5 rounded toward -infinity becomes -1, which lies below an unsigned range. The sweep drives such boundary operands through every type, mode code, rounding field and enable combination. A real-arithmetic model then judges them: first the rounding, then the range test on the rounded value. This shows that invalid-convert, rather than inexact or fraction-rounded, wins whenever the rounding pushes the value out of range.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
    localparam int EXP_W      = 11;
    localparam int FRAC_W     = 52;
    localparam int MANT_W     = FRAC_W + 1;
    localparam int BIAS       = (1 << (EXP_W - 1)) - 1;
    localparam int UNIT_SHIFT = BIAS + FRAC_W;
    localparam int SH_W       = EXP_W + 2;
    localparam int OUT_W      = 64;
    localparam int HALF_W     = OUT_W / 2;
    localparam int WIDE_W     = 2 * OUT_W;

    typedef enum logic [1:0] {
        POL_CLAMP_MIN  = 2'b00,
        POL_CLAMP_ZERO = 2'b01,
        POL_WRAP       = 2'b10,
        POL_BAD        = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef struct packed {
        logic [OUT_W-1:0] res;
        logic             wr_en;
        logic             inv_cvt;
        logic             snan;
        logic             inexact;
        logic             frac_rnd;
        logic             frac_inx;
        logic             int_ovf;
        logic             bad_mode;
    } cvt_out_t;
endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
    import f2i_pkg::*;
(
    input  logic [EXP_W+FRAC_W:0]  op_i,
    output logic                   sign_o,
    output logic                   nan_o,
    output logic                   snan_o,
    output logic [MANT_W-1:0]      mant_o,
    output logic signed [SH_W-1:0] sh_o
);
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic [EXP_W-1:0]  expo_eff;
    logic              expo_zero;

    assign {sign_o, expo, frac} = op_i;
    assign expo_zero = ~|expo;
    assign expo_eff  = expo_zero ? EXP_W'(1) : expo;
    assign nan_o     = (&expo) && (|frac);
    assign snan_o    = nan_o && !frac[FRAC_W-1];
    assign mant_o    = {!expo_zero, frac};
    // weight of the mantissa LSB: value = mant * 2^sh
    assign sh_o      = $signed({2'b00, expo_eff}) - $signed(SH_W'(UNIT_SHIFT));
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  logic [MANT_W-1:0]      mant_i,
    input  logic signed [SH_W-1:0] sh_i,
    input  logic                   sign_i,
    input  rmode_e                 rm_i,
    output logic [WIDE_W-1:0]      mag_o,
    output logic                   huge_o,
    output logic                   inexact_o,
    output logic                   incr_o
);
    localparam int LSH_LIM  = OUT_W;
    localparam int LSH_BITS = $clog2(LSH_LIM);
    localparam int RSH_MAX  = OUT_W - 1;
    localparam int RSH_BITS = $clog2(OUT_W);

    logic [SH_W-1:0]     neg_sh;
    logic [RSH_BITS-1:0] rsh;
    logic [OUT_W-1:0]    wmant;
    logic [OUT_W-1:0]    ipart;
    logic [OUT_W-1:0]    low_mask;
    logic                guard;
    logic                sticky;

    always_comb begin
        mag_o     = '0;
        huge_o    = 1'b0;
        inexact_o = 1'b0;
        incr_o    = 1'b0;
        neg_sh    = -sh_i;
        rsh       = (neg_sh > SH_W'(RSH_MAX)) ? RSH_BITS'(RSH_MAX) : neg_sh[RSH_BITS-1:0];
        wmant     = OUT_W'(mant_i);
        ipart     = wmant >> rsh;
        guard     = wmant[rsh - RSH_BITS'(1)];
        low_mask  = (OUT_W'(1) << (rsh - RSH_BITS'(1))) - OUT_W'(1);
        sticky    = |(wmant & low_mask);
        if (!sh_i[SH_W-1]) begin
            if (sh_i >= $signed(SH_W'(LSH_LIM))) begin
                huge_o = 1'b1;
            end else begin
                mag_o = WIDE_W'(mant_i) << sh_i[LSH_BITS-1:0];
            end
        end else begin
            inexact_o = guard | sticky;
            unique case (rm_i)
                RM_NEAR: incr_o = guard && (sticky || ipart[0]);
                RM_ZERO: incr_o = 1'b0;
                RM_UP:   incr_o = inexact_o && !sign_i;
                RM_DOWN: incr_o = inexact_o && sign_i;
                default: incr_o = 1'b0;
            endcase
            mag_o = WIDE_W'(ipart) + WIDE_W'(incr_o);
        end
    end
endmodule

// File: rtl/f2i_range.sv
module f2i_range
    import f2i_pkg::*;
(
    input  logic [1:0]        itype_i,
    input  logic              sign_i,
    input  logic [WIDE_W-1:0] mag_i,
    input  logic              huge_i,
    output logic [OUT_W-1:0]  hi_o,
    output logic [OUT_W-1:0]  lo_mag_o,
    output logic              above_o,
    output logic              below_o
);
    logic [OUT_W-1:0] span;

    always_comb begin
        span     = itype_i[1] ? '1 : OUT_W'({HALF_W{1'b1}});
        hi_o     = itype_i[0] ? span : (span >> 1);
        lo_mag_o = itype_i[0] ? '0 : ((span >> 1) + OUT_W'(1));
        above_o  = !sign_i && (huge_i || (mag_i > WIDE_W'(hi_o)));
        below_o  = sign_i && (huge_i || (mag_i > WIDE_W'(lo_mag_o)));
    end
endmodule

// File: rtl/fp64_to_int_cvt.sv
module fp64_to_int_cvt
    import f2i_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] op_i,
    input  logic [1:0]  int_type_i,
    input  logic [2:0]  conv_mode_i,
    input  logic [1:0]  rnd_mode_i,
    input  logic        inv_en_i,
    input  logic        ovf_en_i,
    output logic [63:0] result_o,
    output logic        wr_en_o,
    output logic        inv_cvt_o,
    output logic        snan_o,
    output logic        inexact_o,
    output logic        frac_rnd_o,
    output logic        frac_inx_o,
    output logic        int_ovf_o,
    output logic        bad_mode_o
);
    logic                   sign, is_nan, is_snan;
    logic [MANT_W-1:0]      mant;
    logic signed [SH_W-1:0] sh;
    rmode_e                 rm_eff;
    policy_e                policy;
    logic [WIDE_W-1:0]      mag;
    logic                   huge, inx, incr;
    logic [OUT_W-1:0]       hi_lim, lo_mag;
    logic                   above, below;
    logic                   cvi, vex;
    logic [OUT_W-1:0]       tmin, signed_val, raw, ext;
    cvt_out_t               out_d, out_q;

    assign policy = policy_e'(conv_mode_i[2:1]);
    assign rm_eff = conv_mode_i[0] ? RM_ZERO : rmode_e'(rnd_mode_i);

    f2i_classify u_cls (
        .op_i  (op_i),
        .sign_o(sign),
        .nan_o (is_nan),
        .snan_o(is_snan),
        .mant_o(mant),
        .sh_o  (sh)
    );

    f2i_round u_rnd (
        .mant_i   (mant),
        .sh_i     (sh),
        .sign_i   (sign),
        .rm_i     (rm_eff),
        .mag_o    (mag),
        .huge_o   (huge),
        .inexact_o(inx),
        .incr_o   (incr)
    );

    f2i_range u_rng (
        .itype_i (int_type_i),
        .sign_i  (sign),
        .mag_i   (mag),
        .huge_i  (huge),
        .hi_o    (hi_lim),
        .lo_mag_o(lo_mag),
        .above_o (above),
        .below_o (below)
    );

    always_comb begin
        cvi        = is_nan || above || below;
        vex        = inv_en_i && (is_snan || cvi);
        tmin       = OUT_W'(0) - lo_mag;
        signed_val = sign ? (OUT_W'(0) - mag[OUT_W-1:0]) : mag[OUT_W-1:0];
        unique case (policy)
            POL_CLAMP_MIN, POL_CLAMP_ZERO: begin
                if (is_nan)     raw = (policy == POL_CLAMP_MIN) ? tmin : '0;
                else if (above) raw = hi_lim;
                else if (below) raw = tmin;
                else            raw = signed_val;
            end
            POL_WRAP: raw = is_nan ? '0 : signed_val;
            default:  raw = '0;
        endcase
        if (int_type_i[1])      ext = raw;
        else if (int_type_i[0]) ext = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
        else                    ext = {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};

        out_d = '0;
        if (policy == POL_BAD) begin
            out_d.bad_mode = 1'b1;
        end else begin
            out_d.wr_en    = !vex;
            out_d.res      = vex ? '0 : ext;
            out_d.inv_cvt  = cvi;
            out_d.snan     = is_snan;
            out_d.inexact  = !cvi && inx;
            out_d.frac_rnd = !vex && !cvi && incr;
            out_d.frac_inx = !vex && !cvi && inx;
            out_d.int_ovf  = ovf_en_i && cvi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o   = out_q.res;
    assign wr_en_o    = out_q.wr_en;
    assign inv_cvt_o  = out_q.inv_cvt;
    assign snan_o     = out_q.snan;
    assign inexact_o  = out_q.inexact;
    assign frac_rnd_o = out_q.frac_rnd;
    assign frac_inx_o = out_q.frac_inx;
    assign int_ovf_o  = out_q.int_ovf;
    assign bad_mode_o = out_q.bad_mode;
endmodule

// File: rtl/fp64_to_int_cvt_chk.sv
module fp64_to_int_cvt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  int_type_i,
    input logic [2:0]  conv_mode_i,
    input logic        ovf_en_i,
    input logic [63:0] result_o,
    input logic        wr_en_o,
    input logic        inv_cvt_o,
    input logic        snan_o,
    input logic        inexact_o,
    input logic        frac_rnd_o,
    input logic        frac_inx_o,
    input logic        int_ovf_o,
    input logic        bad_mode_o
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_bad_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(conv_mode_i[2:1]) == 2'b11) |-> (bad_mode_o && !wr_en_o && result_o == 64'd0));

    p_cvi_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_cvt_o |-> (!inexact_o && !frac_rnd_o));

    p_fi_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (frac_inx_o == inexact_o));

    p_snan_is_cvi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snan_o |-> inv_cvt_o);

    p_nowrite_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_o && !bad_mode_o) |-> (result_o == 64'd0 && !frac_rnd_o && !frac_inx_o));

    p_ovf_needs_cvi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        int_ovf_o |-> inv_cvt_o);

    p_ovf_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(ovf_en_i)) |-> !int_ovf_o);

    p_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en_o && $past(int_type_i) == 2'b00) |-> (result_o[63:32] == {32{result_o[31]}}));

    p_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en_o && $past(int_type_i) == 2'b01) |-> (result_o[63:32] == 32'd0));
endmodule

bind fp64_to_int_cvt fp64_to_int_cvt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_type_i (int_type_i),
    .conv_mode_i(conv_mode_i),
    .ovf_en_i   (ovf_en_i),
    .result_o   (result_o),
    .wr_en_o    (wr_en_o),
    .inv_cvt_o  (inv_cvt_o),
    .snan_o     (snan_o),
    .inexact_o  (inexact_o),
    .frac_rnd_o (frac_rnd_o),
    .frac_inx_o (frac_inx_o),
    .int_ovf_o  (int_ovf_o),
    .bad_mode_o (bad_mode_o)
);

// File: tb/fp64_to_int_cvt_tb_top.sv
module fp64_to_int_cvt_tb_top;
    import f2i_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_i = '0;
    logic [1:0]  int_type_i = '0;
    logic [2:0]  conv_mode_i = '0;
    logic [1:0]  rnd_mode_i = '0;
    logic        inv_en_i = 1'b0;
    logic        ovf_en_i = 1'b0;
    logic [63:0] result_o;
    logic        wr_en_o, inv_cvt_o, snan_o, inexact_o;
    logic        frac_rnd_o, frac_inx_o, int_ovf_o, bad_mode_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    fp64_to_int_cvt dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .int_type_i(int_type_i),
        .conv_mode_i(conv_mode_i), .rnd_mode_i(rnd_mode_i),
        .inv_en_i(inv_en_i), .ovf_en_i(ovf_en_i), .result_o(result_o),
        .wr_en_o(wr_en_o), .inv_cvt_o(inv_cvt_o), .snan_o(snan_o),
        .inexact_o(inexact_o), .frac_rnd_o(frac_rnd_o), .frac_inx_o(frac_inx_o),
        .int_ovf_o(int_ovf_o), .bad_mode_o(bad_mode_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s op=%h type=%0d mode=%0d rnd=%0d: actual %h expected %h",
                     tag, op_i, int_type_i, conv_mode_i, rnd_mode_i, act, exp);
        end
    endtask

    function automatic real pow2(input int n);
        real p = 1.0;
        for (int i = 0; i < n; i++) p = p * 2.0;
        return p;
    endfunction

    function automatic logic [63:0] to_u64(input real x);
        if (x >= pow2(63)) return 64'(longint'(x - pow2(63))) | 64'h8000_0000_0000_0000;
        return 64'(longint'(x));
    endfunction

    function automatic real round_ref(input real v, input logic [1:0] rm);
        real fl, d;
        case (rm)
            2'b00: begin
                fl = $floor(v);
                d  = v - fl;
                if (d > 0.5)      return fl + 1.0;
                else if (d < 0.5) return fl;
                else              return ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
            end
            2'b01:   return (v < 0.0) ? -$floor(-v) : $floor(v);
            2'b10:   return $ceil(v);
            default: return $floor(v);
        endcase
    endfunction

    function automatic cvt_out_t ref_model(input logic [63:0] b, input logic [1:0] it,
                                           input logic [2:0] cm, input logic [1:0] rm,
                                           input logic ie, input logic oe);
        cvt_out_t o;
        real v, r, ar, hi_r, lo_r;
        logic is_nan, is_inf, is_snan, above, below, cvi, vex, xx, fr;
        logic [63:0] tmin, tmax, val, low;
        logic [1:0] erm;
        int k;
        o = '0;
        if (cm[2:1] == 2'b11) begin // R1
            o.bad_mode = 1'b1;
            return o;
        end
        is_nan  = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
        is_inf  = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
        is_snan = is_nan && !b[51];                  // R9
        erm     = cm[0] ? 2'b01 : rm;                // R2
        hi_r    = it[0] ? pow2(it[1] ? 64 : 32) : pow2(it[1] ? 63 : 31);
        lo_r    = it[0] ? 0.0 : -pow2(it[1] ? 63 : 31);
        v = 0.0; r = 0.0; above = 1'b0; below = 1'b0;
        if (is_inf) begin
            above = !b[63];
            below = b[63];
        end else if (!is_nan) begin
            v = $bitstoreal(b);
            r = round_ref(v, erm);
            above = (r >= hi_r);
            below = (r < lo_r);
        end
        cvi = is_nan || is_inf || above || below;    // R7
        case (it)
            2'b00:   begin tmin = 64'hFFFF_FFFF_8000_0000; tmax = 64'h0000_0000_7FFF_FFFF; end
            2'b01:   begin tmin = 64'd0;                   tmax = 64'h0000_0000_FFFF_FFFF; end
            2'b10:   begin tmin = 64'h8000_0000_0000_0000; tmax = 64'h7FFF_FFFF_FFFF_FFFF; end
            default: begin tmin = 64'd0;                   tmax = 64'hFFFF_FFFF_FFFF_FFFF; end
        endcase
        ar = (r < 0.0) ? -r : r;
        if (cm[2:1] == 2'b10) begin // R5 wrap, then R6 width handling
            if (is_nan || is_inf) begin
                val = 64'd0;
            end else begin
                if (ar >= pow2(64)) begin
                    k   = int'(b[62:52]) - 1075;
                    low = (k >= 64) ? 64'd0 : ({12'd1, b[51:0]} << k);
                end else begin
                    low = to_u64(ar);
                end
                val = (r < 0.0) ? (64'd0 - low) : low;
                if (it == 2'b00)      val = {{32{val[31]}}, val[31:0]};
                else if (it == 2'b01) val = {32'd0, val[31:0]};
            end
        end else begin // R3 and R4 clamping
            if (is_nan)     val = (cm[2:1] == 2'b00) ? tmin : 64'd0;
            else if (above) val = tmax;
            else if (below) val = tmin;
            else            val = (r < 0.0) ? (64'd0 - to_u64(-r)) : to_u64(r);
        end
        xx  = !cvi && (r != v);                                        // R8
        fr  = !cvi && (ar > ((v < 0.0) ? -v : v));
        vex = ie && (is_snan || cvi);                                  // R10
        o.res      = vex ? 64'd0 : val;
        o.wr_en    = !vex;
        o.inv_cvt  = cvi;
        o.snan     = is_snan;
        o.inexact  = xx;
        o.frac_rnd = !vex && fr;
        o.frac_inx = !vex && xx;
        o.int_ovf  = oe && cvi;                                        // R11
        return o;
    endfunction

    task automatic run_one(input logic [63:0] b, input logic [1:0] it, input logic [2:0] cm,
                           input logic [1:0] rm, input logic ie, input logic oe);
        cvt_out_t e;
        string rtag;
        op_i = b; int_type_i = it; conv_mode_i = cm; rnd_mode_i = rm;
        inv_en_i = ie; ovf_en_i = oe;
        @(negedge clk);
        e = ref_model(b, it, cm, rm, ie, oe);
        if (cm[2:1] == 2'b11)      rtag = "R1";
        else if (!e.wr_en)         rtag = "R10";
        else if (cm[2:1] == 2'b00) rtag = "R3 R2 R6";
        else if (cm[2:1] == 2'b01) rtag = "R4 R2 R6";
        else                       rtag = "R5 R2 R6";
        chk({rtag, " result"}, result_o, e.res);
        chk("R10 wr_en", {63'd0, wr_en_o}, {63'd0, e.wr_en});
        chk("R7 inv_cvt", {63'd0, inv_cvt_o}, {63'd0, e.inv_cvt});
        chk("R9 snan", {63'd0, snan_o}, {63'd0, e.snan});
        chk("R8 inexact", {63'd0, inexact_o}, {63'd0, e.inexact});
        chk("R8 frac_rnd", {63'd0, frac_rnd_o}, {63'd0, e.frac_rnd});
        chk("R8 frac_inx", {63'd0, frac_inx_o}, {63'd0, e.frac_inx});
        chk("R11 int_ovf", {63'd0, int_ovf_o}, {63'd0, e.int_ovf});
        chk("R1 bad_mode", {63'd0, bad_mode_o}, {63'd0, e.bad_mode});
    endtask

    logic [63:0] vals [30];

    initial begin
        vals[0]  = 64'h0000_0000_0000_0000;
        vals[1]  = 64'h8000_0000_0000_0000;
        vals[2]  = 64'h7FF0_0000_0000_0000;
        vals[3]  = 64'hFFF0_0000_0000_0000;
        vals[4]  = 64'h7FF8_0000_0000_0000;
        vals[5]  = 64'h7FF0_0000_0000_0001;
        vals[6]  = 64'hFFF4_0000_0000_0000;
        vals[7]  = 64'hFFF8_0000_0000_0001;
        vals[8]  = $realtobits(2147483648.0);
        vals[9]  = $realtobits(-2147483648.5);
        vals[10] = $realtobits(9223372036854775808.0);
        vals[11] = $realtobits(18446744073709551616.0);
        vals[12] = $realtobits(1.0e30);
        vals[13] = $realtobits(-1.0e30);
        vals[14] = $realtobits(2.5);
        vals[15] = $realtobits(-2.5);
        vals[16] = $realtobits(0.5);
        vals[17] = $realtobits(-0.5);
        vals[18] = $realtobits(1.5);
        vals[19] = $realtobits(3.7);
        vals[20] = $realtobits(-7.25);
        vals[21] = $realtobits(2147483647.5);
        vals[22] = $realtobits(4294967295.5);
        vals[23] = $realtobits(-1.0);
        vals[24] = 64'h0000_0000_0000_0001;
        vals[25] = $realtobits(1.2e19);
        vals[26] = $realtobits(-9.3e18);
        vals[27] = $realtobits(123456789012.75);
        vals[28] = $realtobits(-2147483648.0);
        vals[29] = $realtobits(9223372036854774784.0);

        // R12: reset holds every output at zero even with live inputs
        op_i = $realtobits(3.5); conv_mode_i = 3'd6; ovf_en_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R12 reset result", result_o, 64'd0);
        chk("R12 reset flags", {55'd0, wr_en_o, inv_cvt_o, snan_o, inexact_o, frac_rnd_o,
                               frac_inx_o, int_ovf_o, bad_mode_o}, 64'd0);
        conv_mode_i = 3'd0; ovf_en_i = 1'b0; op_i = '0;
        rst_n = 1'b1;
        @(negedge clk);

        // R12: one-cycle latency
        op_i = $realtobits(3.0); int_type_i = 2'd2; conv_mode_i = 3'd1;
        @(negedge clk);
        chk("R12 latency first", result_o, 64'd3);
        op_i = $realtobits(5.0);
        #1;
        chk("R12 latency hold", result_o, 64'd3);
        @(negedge clk);
        chk("R12 latency next", result_o, 64'd5);

        for (int vi = 0; vi < 30; vi++)
            for (int it = 0; it < 4; it++)
                for (int cm = 0; cm < 8; cm++)
                    for (int rm = 0; rm < 4; rm++)
                        for (int en = 0; en < 4; en++)
                            run_one(vals[vi], 2'(it), 3'(cm), 2'(rm), en[1], en[0]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule